// File: doc/BRIEF.md
# Power-State Handshake Sequencer

This block runs the power sequence between a management controller and a user processor domain. After power-on reset it waits until the management core reports that its own clock and reset are settled. It then requests a clock/DLL configuration, followed by a pad-routing configuration. Next it selects the full-speed user clock and releases the user-domain reset. The clock generator, DLL and pad drivers are outside the block. Each one is modelled as a level request output paired with an acknowledge input.

The user processor talks to the sequencer by writing command codes into a small register mailbox on a 32-bit Wishbone slave port. Each command write raises an interrupt line towards the management side.

- A "running OK" report gets an acknowledge status and turns off the enable pin of the external clock-generator supply.
- A "go low power" request drives the clock/DLL settings to their lowest-power point and then reports the low-power state.
- A "go full power" request, or an RTC wake pulse, restores the settings and then posts a "now full power" reply.

Any configuration step whose acknowledge never arrives sends the sequencer to a terminal error state.

Top module: `pwr_handshake_seq`

## Requirements
- R1: While `rst_ni` is low, and afterwards until `core_rdy_i` is seen high, the state code is 0 and no request is raised. In this period `ext_cpg_en_o`=1, `user_rst_no`=0, `user_clk_full_o`=0 and `irq_o`=0.
- R2: The clock/DLL request (`clk_cfg_req_o`) comes first and holds until `clk_cfg_ack_i`. Only after that is `pad_cfg_req_o` raised, and it holds until `pad_cfg_ack_i`. The two requests are never high together.
- R3: `user_clk_full_o` goes high one cycle before `user_rst_no` goes high. The user reset is never released while the clock is not at full speed.
- R4: Writing command 0x01 while waiting for the user report moves to the run state. It sets the status register to 0x81 and drives `ext_cpg_en_o` low, and the pin never returns high before reset. Command 0x01 in any other state has no effect.
- R5: Every write to the command register sets the pending bit (bit 0 of offset 0x8) and `irq_o`. Writing 1 to that bit clears it, unless a command is written in the same cycle.
- R6: Command 0x02 in the run state raises `clk_cfg_req_o` with `clk_lp_o`=1 and waits for `clk_cfg_ack_i`. It then enters low power, sets status to 0x82 and keeps `clk_lp_o`=1.
- R7: In low power, command 0x03 or a high `rtc_wake_i` raises `clk_cfg_req_o` with `clk_lp_o`=0 and waits for `clk_cfg_ack_i`. It then returns to run with status 0x83. `rtc_wake_i` in any other state is ignored.
- R8: Command 0x02 outside the run state, or 0x03 outside low power, leaves the state unchanged and sets the sticky protocol-error bit (bit 1 of offset 0x8).
- R9: If a request waits TIMEOUT cycles without its acknowledge, the sequencer enters the error state (code 10). It then sets `err_o` and bit 2 of offset 0x8, and it stays there until reset whatever the inputs do.
- R10: Bus access behaves as follows.
  - `wb_ack_o` rises in the cycle after a strobe is accepted and lasts one cycle.
  - Reads return the command byte at 0x0, the status byte at 0x4 and the flags at 0x8.
  - Reads at 0xC return the state code: 0 reset, 1 clock config, 2 pad config, 3 clock full, 4 release, 5 wait report, 6 run, 7 entering low, 8 low power, 9 exiting low, 10 error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| core_rdy_i | input | 1 | Management core clock and reset are settled |
| clk_cfg_ack_i | input | 1 | Clock/DLL configuration done |
| pad_cfg_ack_i | input | 1 | Pad routing configuration done |
| rtc_wake_i | input | 1 | RTC wake event |
| wb_cyc_i | input | 1 | Bus cycle |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Bus write enable |
| wb_adr_i | input | ADR_W | Byte address |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data |
| wb_ack_o | output | 1 | Bus acknowledge |
| clk_cfg_req_o | output | 1 | Clock/DLL configuration request |
| clk_lp_o | output | 1 | Requested clock setting is the lowest-power one |
| pad_cfg_req_o | output | 1 | Pad routing configuration request |
| user_clk_full_o | output | 1 | User clock at full speed |
| user_rst_no | output | 1 | User-domain reset, active low |
| ext_cpg_en_o | output | 1 | External clock-generator supply enable |
| irq_o | output | 1 | Mailbox interrupt |
| err_o | output | 1 | Acknowledge timeout error |

## Verification
The bench holds the clock acknowledge back for several cycles. A design that overlapped the two configuration steps would raise the pad request too early. It checks the single cycle between selecting full speed and releasing the user reset, which exposes a swapped order. Misplaced go-low and go-full commands, plus an RTC pulse in the run state, must leave the state code alone; a design that decoded commands regardless of state would move. Finally, a low-power entry whose acknowledge never comes must land in the error state and stay there even after a late acknowledge arrives.

// File: rtl/pwr_handshake_seq.sv
module pwr_handshake_seq #(
  parameter int ADR_W   = 4,
  parameter int CNT_W   = 16,
  parameter int TIMEOUT = 1000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             core_rdy_i,
  input  logic             clk_cfg_ack_i,
  input  logic             pad_cfg_ack_i,
  input  logic             rtc_wake_i,
  input  logic             wb_cyc_i,
  input  logic             wb_stb_i,
  input  logic             wb_we_i,
  input  logic [ADR_W-1:0] wb_adr_i,
  input  logic [31:0]      wb_dat_i,
  output logic [31:0]      wb_dat_o,
  output logic             wb_ack_o,
  output logic             clk_cfg_req_o,
  output logic             clk_lp_o,
  output logic             pad_cfg_req_o,
  output logic             user_clk_full_o,
  output logic             user_rst_no,
  output logic             ext_cpg_en_o,
  output logic             irq_o,
  output logic             err_o
);
  localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(TIMEOUT - 1);
  localparam logic [7:0] CMD_OK = 8'h01, CMD_LOW = 8'h02, CMD_FULL = 8'h03;

  typedef enum logic [3:0] {
    S_RESET, S_CFG_CLK, S_CFG_PADS, S_CLK_FULL, S_RELEASE, S_WAIT_OK,
    S_RUN, S_ENTER_LOW, S_LOW, S_EXIT_LOW, S_ERROR
  } state_t;

  state_t           state, state_nx;
  logic [CNT_W-1:0] tmo_cnt;
  logic [7:0]       cmd_q, status_q;
  logic             pend_q, proto_q, tmo_q;

  logic       unused_bits;
  assign unused_bits = ^{wb_dat_i[31:8], wb_adr_i[1:0]};

  logic       bus_acc, bus_wr, cmd_wr, clr_wr;
  logic [1:0] reg_sel;
  logic [7:0] cmd_val;
  assign bus_acc = wb_cyc_i & wb_stb_i & ~wb_ack_o;
  assign bus_wr  = bus_acc & wb_we_i;
  assign reg_sel = wb_adr_i[3:2];
  assign cmd_val = wb_dat_i[7:0];
  assign cmd_wr  = bus_wr && reg_sel == 2'd0;
  assign clr_wr  = bus_wr && reg_sel == 2'd2 && wb_dat_i[0];

  logic go_ok, go_low, go_full, bad_cmd;
  assign go_ok   = cmd_wr && cmd_val == CMD_OK && state == S_WAIT_OK;
  assign go_low  = cmd_wr && cmd_val == CMD_LOW;
  assign go_full = cmd_wr && cmd_val == CMD_FULL;
  assign bad_cmd = (go_low && state != S_RUN) || (go_full && state != S_LOW);

  logic waiting, step_ack, timed_out;
  assign waiting   = state inside {S_CFG_CLK, S_CFG_PADS, S_ENTER_LOW, S_EXIT_LOW};
  assign step_ack  = (state == S_CFG_PADS) ? pad_cfg_ack_i : clk_cfg_ack_i;
  assign timed_out = waiting && !step_ack && tmo_cnt == TMO_LAST;

  assign clk_cfg_req_o = state inside {S_CFG_CLK, S_ENTER_LOW, S_EXIT_LOW};
  assign pad_cfg_req_o = state == S_CFG_PADS;
  assign clk_lp_o      = state inside {S_ENTER_LOW, S_LOW};
  assign irq_o         = pend_q;
  assign err_o         = tmo_q;

  always_comb begin
    state_nx = state;
    unique case (state)
      S_RESET:     if (core_rdy_i) state_nx = S_CFG_CLK;
      S_CFG_CLK:   if (step_ack) state_nx = S_CFG_PADS;
      S_CFG_PADS:  if (step_ack) state_nx = S_CLK_FULL;
      S_CLK_FULL:  state_nx = S_RELEASE;
      S_RELEASE:   state_nx = S_WAIT_OK;
      S_WAIT_OK:   if (go_ok) state_nx = S_RUN;
      S_RUN:       if (go_low) state_nx = S_ENTER_LOW;
      S_ENTER_LOW: if (step_ack) state_nx = S_LOW;
      S_LOW:       if (go_full || rtc_wake_i) state_nx = S_EXIT_LOW;
      S_EXIT_LOW:  if (step_ack) state_nx = S_RUN;
      S_ERROR:     state_nx = S_ERROR;
      default:     state_nx = S_ERROR;
    endcase
    if (timed_out) state_nx = S_ERROR;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state           <= S_RESET;
      tmo_cnt         <= '0;
      user_clk_full_o <= 1'b0;
      user_rst_no     <= 1'b0;
      ext_cpg_en_o    <= 1'b1;
      status_q        <= 8'h00;
    end else begin
      state <= state_nx;
      if (state_nx != state) tmo_cnt <= '0;
      else if (waiting)      tmo_cnt <= tmo_cnt + 1'b1;
      if (state == S_CLK_FULL) user_clk_full_o <= 1'b1;
      if (state == S_RELEASE)  user_rst_no <= 1'b1;
      if (go_ok) begin
        ext_cpg_en_o <= 1'b0;
        status_q     <= 8'h81;
      end
      if (state == S_ENTER_LOW && state_nx == S_LOW) status_q <= 8'h82;
      if (state == S_EXIT_LOW && state_nx == S_RUN)  status_q <= 8'h83;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q    <= 8'h00;
      pend_q   <= 1'b0;
      proto_q  <= 1'b0;
      tmo_q    <= 1'b0;
      wb_ack_o <= 1'b0;
      wb_dat_o <= '0;
    end else begin
      wb_ack_o <= bus_acc;
      if (cmd_wr) cmd_q <= cmd_val;
      if (cmd_wr)      pend_q <= 1'b1;
      else if (clr_wr) pend_q <= 1'b0;
      if (bad_cmd)   proto_q <= 1'b1;
      if (timed_out) tmo_q <= 1'b1;
      if (bus_acc && !wb_we_i) begin
        unique case (reg_sel)
          2'd0: wb_dat_o <= {24'd0, cmd_q};
          2'd1: wb_dat_o <= {24'd0, status_q};
          2'd2: wb_dat_o <= {29'd0, tmo_q, proto_q, pend_q};
          2'd3: wb_dat_o <= {28'd0, state};
          default: wb_dat_o <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/pwr_handshake_seq_chk.sv
module pwr_handshake_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic clk_cfg_req_o,
  input logic clk_cfg_ack_i,
  input logic pad_cfg_req_o,
  input logic clk_lp_o,
  input logic user_clk_full_o,
  input logic user_rst_no,
  input logic ext_cpg_en_o,
  input logic irq_o,
  input logic err_o,
  input logic wb_ack_o,
  input logic wb_cyc_i,
  input logic wb_stb_i
);
  AST_REQ_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(clk_cfg_req_o && pad_cfg_req_o));                                              // R2
  AST_PAD_AFTER_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pad_cfg_req_o) |-> $past(clk_cfg_req_o && clk_cfg_ack_i));                 // R2
  AST_FULL_BEFORE_REL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(user_rst_no) |-> $past(user_clk_full_o));                                  // R3
  AST_REL_NEEDS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    user_rst_no |-> user_clk_full_o);                                                // R3
  AST_CPG_STAYS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_cpg_en_o |=> !ext_cpg_en_o);                                                // R4
  AST_IRQ_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> wb_ack_o);                                                      // R5
  AST_LP_WITH_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_lp_o) |-> clk_cfg_req_o);                                              // R6
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o && !clk_cfg_req_o && !pad_cfg_req_o);                            // R9
  AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_ack_o |=> !wb_ack_o);                                                         // R10
  AST_ACK_AFTER_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_ack_o |-> $past(wb_cyc_i && wb_stb_i));                                       // R10
endmodule

bind pwr_handshake_seq pwr_handshake_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clk_cfg_req_o(clk_cfg_req_o),
  .clk_cfg_ack_i(clk_cfg_ack_i), .pad_cfg_req_o(pad_cfg_req_o), .clk_lp_o(clk_lp_o),
  .user_clk_full_o(user_clk_full_o), .user_rst_no(user_rst_no),
  .ext_cpg_en_o(ext_cpg_en_o), .irq_o(irq_o), .err_o(err_o),
  .wb_ack_o(wb_ack_o), .wb_cyc_i(wb_cyc_i), .wb_stb_i(wb_stb_i)
);

// File: tb/pwr_handshake_seq_tb.sv
module pwr_handshake_seq_tb;
  logic clk = 0, rst_n = 0;
  logic core_rdy = 0, clk_ack = 0, pad_ack = 0, rtc = 0;
  logic cyc = 0, stb = 0, we = 0;
  logic [3:0] adr = '0;
  logic [31:0] wdat = '0, rdat;
  logic ack, clk_req, lp, pad_req, ufull, urst_n, cpg_en, irq, err;

  pwr_handshake_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .core_rdy_i(core_rdy), .clk_cfg_ack_i(clk_ack),
    .pad_cfg_ack_i(pad_ack), .rtc_wake_i(rtc), .wb_cyc_i(cyc), .wb_stb_i(stb),
    .wb_we_i(we), .wb_adr_i(adr), .wb_dat_i(wdat), .wb_dat_o(rdat), .wb_ack_o(ack),
    .clk_cfg_req_o(clk_req), .clk_lp_o(lp), .pad_cfg_req_o(pad_req),
    .user_clk_full_o(ufull), .user_rst_no(urst_n), .ext_cpg_en_o(cpg_en),
    .irq_o(irq), .err_o(err)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (ack && !we) begin
      if (exp_q.size() == 0) check("R10 unexpected read ack", 1, 0);
      else check(tag_q.pop_front(), rdat, exp_q.pop_front());
    end
  end

  task automatic bus(input logic w, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cyc = 1; stb = 1; we = w; adr = a; wdat = d;
    @(negedge clk);
    check("R10 ack one cycle after strobe", {31'd0, ack}, 1);
    #1 cyc = 0; stb = 0;
    @(negedge clk);
    check("R10 ack lasts one cycle", {31'd0, ack}, 0);
    #1 we = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    bus(0, a, 0);
  endtask

  task automatic pulse_clk_ack;
    @(negedge clk); clk_ack = 1;
    @(negedge clk); clk_ack = 0;
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    check("watchdog expired", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset cpg enable", {31'd0, cpg_en}, 1);
    check("R1 reset user reset", {31'd0, urst_n}, 0);
    check("R1 reset clk full", {31'd0, ufull}, 0);
    check("R1 reset requests", {30'd0, clk_req, pad_req}, 0);
    check("R1 reset irq", {31'd0, irq}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 no request before core ready", {30'd0, clk_req, pad_req}, 0);
    rd(4'hC, 0, "R1 state waits for core ready");
    core_rdy = 1;
    @(negedge clk);
    check("R2 clock request first", {30'd0, clk_req, pad_req}, 2'b10);
    repeat (5) @(negedge clk);
    check("R2 pads wait for clock ack", {30'd0, clk_req, pad_req}, 2'b10);
    clk_ack = 1;
    @(negedge clk); clk_ack = 0;
    check("R2 pad request after clock ack", {30'd0, clk_req, pad_req}, 2'b01);
    check("R3 user held in reset", {31'd0, urst_n}, 0);
    repeat (3) @(negedge clk);
    check("R2 pad request holds", {31'd0, pad_req}, 1);
    pad_ack = 1;
    @(negedge clk); pad_ack = 0;
    check("R3 not yet full", {30'd0, ufull, urst_n}, 2'b00);
    @(negedge clk);
    check("R3 full speed before release", {30'd0, ufull, urst_n}, 2'b10);
    @(negedge clk);
    check("R3 user reset released", {30'd0, ufull, urst_n}, 2'b11);
    rd(4'hC, 5, "R10 state wait report");

    bus(1, 4'h0, 32'h03);
    rd(4'h8, 32'h3, "R8 go-full outside low sets proto and R5 pending");
    rd(4'hC, 5, "R8 misplaced go-full keeps state");
    bus(1, 4'h8, 32'h1);
    rd(4'h8, 32'h2, "R5 write-one clears pending");
    check("R5 irq low after clear", {31'd0, irq}, 0);

    bus(1, 4'h0, 32'h01);
    check("R4 cpg supply off", {31'd0, cpg_en}, 0);
    check("R5 irq on command", {31'd0, irq}, 1);
    rd(4'h4, 32'h81, "R4 status acknowledged");
    rd(4'hC, 6, "R4 state run");
    rd(4'h0, 32'h01, "R10 command readback");

    rtc = 1; @(negedge clk); rtc = 0;
    @(negedge clk);
    rd(4'hC, 6, "R7 rtc ignored in run");
    check("R7 no request on rtc in run", {31'd0, clk_req}, 0);

    bus(1, 4'h0, 32'h02);
    check("R6 low entry request", {30'd0, clk_req, lp}, 2'b11);
    rd(4'hC, 7, "R6 state entering low");
    pulse_clk_ack;
    rd(4'hC, 8, "R6 state low power");
    rd(4'h4, 32'h82, "R6 status now low");
    check("R6 lowest setting held", {30'd0, clk_req, lp}, 2'b01);

    bus(1, 4'h0, 32'h02);
    rd(4'hC, 8, "R8 go-low in low power keeps state");

    rtc = 1; @(negedge clk); rtc = 0;
    check("R7 rtc wake request", {30'd0, clk_req, lp}, 2'b10);
    pulse_clk_ack;
    rd(4'hC, 6, "R7 back to run after rtc");
    rd(4'h4, 32'h83, "R7 status now full");

    bus(1, 4'h0, 32'h02);
    pulse_clk_ack;
    bus(1, 4'h0, 32'h03);
    check("R7 go-full request", {30'd0, clk_req, lp}, 2'b10);
    pulse_clk_ack;
    rd(4'hC, 6, "R7 back to run after command");

    bus(1, 4'h0, 32'h01);
    check("R4 cpg stays off", {31'd0, cpg_en}, 0);
    rd(4'hC, 6, "R4 repeat report ignored");

    bus(1, 4'h0, 32'h02);
    repeat (1100) @(negedge clk);
    check("R9 err flag", {31'd0, err}, 1);
    rd(4'hC, 10, "R9 error state");
    rd(4'h8, 32'h7, "R9 timeout flag");
    pulse_clk_ack;
    rd(4'hC, 10, "R9 late ack ignored");
    check("R9 no request in error", {30'd0, clk_req, pad_req}, 0);

    repeat (3) @(negedge clk);
    check("R10 all reads answered", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule